// File: doc/BRIEF.md
# Dual-Mode PWM Duty Controller

This block produces the on/off chopping signal that a brushless motor commutation stage applies to its low-side switches. It runs in one of two modes. In level mode, a digital control word is compared against an internal triangular carrier that sweeps between a lower and an upper bound. Words at or below the lower bound give no drive, words at or above the upper bound give continuous drive, and words in between give a duty that rises with the word. In pulse mode, an external active-low PWM pin sets the on time directly. The pin is brought into the clock domain through a short synchronizer, and an undriven pin, which floats high, means the output is off.

The carrier rate comes from a prescaler whose divide value is an input, so the carrier can be placed near the usual 15 to 25 kHz band, with about 20 kHz as the nominal setting, from any system clock. A control word is adopted only at a carrier period boundary, so a change can never split a period into a glitch. A cycle-by-cycle current limit input cuts the rest of the on time: once it is seen, the output stays off until the next period boundary.

Top module: `pwm_duty_ctrl`

## Requirements
- R1: During and after reset the output is low; the active control word resets to 0, so the output stays low until the first carrier period boundary after reset.
- R2: In level mode (`mode_pulse` = 0), an active word at or below `LO` gives 0 on-ticks per carrier period.
- R3: In level mode, an active word at or above `HI` keeps the output high for the whole carrier period when no overcurrent is latched.
- R4: The carrier steps LO, LO+1 … HI-1 and back down to LO+1, so one period is 2·(HI−LO−1) ticks. In level mode an active word of LO+k (0 < k < HI−LO) gives exactly 2k−1 on-ticks per period.
- R5: The carrier advances once every `presc_div`+1 clock cycles, so one period lasts 2·(HI−LO−1)·(`presc_div`+1) clock cycles.
- R6: A new control word is loaded only at the carrier period boundary, which is the clock edge where the carrier returns to LO. Between boundaries, changes of `ctl_word` have no effect on the output.
- R7: In pulse mode (`mode_pulse` = 1), the output is high exactly when `ext_pwm_n` is low, delayed by `SYNC_STAGES` clock cycles. `ctl_word` has no effect in this mode. The synchronizer resets to the high (off) level.
- R8: In level mode, `ext_pwm_n` has no effect on the output.
- R9: When `oc_flag` is high in a cycle that is not a period boundary, the output is low from the next cycle until the end of the current carrier period, in either mode.
- R10: At a period boundary, the overcurrent latch takes the value of `oc_flag` in that cycle. A flag that is still high keeps the whole next period off; otherwise drive resumes with the new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_div | input | PW | Carrier tick divider; one tick per presc_div+1 cycles |
| ctl_word | input | CW | Level-mode control word |
| mode_pulse | input | 1 | 0 = level mode, 1 = pulse mode |
| ext_pwm_n | input | 1 | External active-low PWM pin (asynchronous) |
| oc_flag | input | 1 | Overcurrent indication from the current limiter |
| pwm_on | output | 1 | Low-side chopping enable, high = drive on |

## Verification
In level mode the bench counts on-cycles across one whole carrier period, which does not depend on phase. It does this for words at zero, at the lower bound, one above it, at mid-range, just below and at the upper bound, and above it. Together these separate saturation from off-by-one errors in the compare. Repeating a mid-range word with divider values of 1 and 3 shows whether the prescaler stretches the period or changes the ratio. A one-tick word gives a pulse that marks the period start. With that reference, the bench changes the word and raises overcurrent at known offsets: a word adopted early, an overcurrent cut that ends too soon, or a latch that does not clear or re-arm at the boundary each give a different count. In pulse mode, the bench checks the pin's polarity, its two-cycle delay and the pulse width it carries, and confirms that the control word is ignored.

// File: rtl/pwmdc_pkg.sv
package pwmdc_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_PULSE = 1'b1
    } drive_mode_e;

    // Per-cycle carrier events shared by the carrier and the gate stage
    typedef struct packed {
        logic tick;   // carrier advances this cycle
        logic wrap;   // carrier returns to its lower bound this cycle
    } car_evt_t;

    // Carrier period length in ticks for a given pair of bounds
    function automatic int unsigned period_ticks(input int unsigned lo, input int unsigned hi);
        return 2 * (hi - lo - 1);
    endfunction

endpackage

// File: rtl/pwmdc_prescaler.sv
module pwmdc_prescaler #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] cnt_q;

    // >= keeps the divider bounded if div is lowered mid-count
    assign tick = (cnt_q >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwmdc_carrier.sv
module pwmdc_carrier
    import pwmdc_pkg::*;
#(
    parameter int CW = 8,
    parameter int LO = 48,
    parameter int HI = 208
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic [CW-1:0] level,
    output car_evt_t      evt
);
    localparam logic [CW-1:0] BOT      = CW'(LO);
    localparam logic [CW-1:0] BOT_NEXT = CW'(LO + 1);
    localparam logic [CW-1:0] TOP      = CW'(HI - 1);
    localparam logic [CW-1:0] TOP_PREV = CW'(HI - 2);

    logic rising_q;

    assign evt.tick = tick;
    assign evt.wrap = tick && !rising_q && (level == BOT_NEXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            level    <= BOT;
            rising_q <= 1'b1;
        end else if (tick) begin
            if (rising_q) begin
                if (level == TOP) begin
                    level    <= TOP_PREV;
                    rising_q <= 1'b0;
                end else begin
                    level <= level + 1'b1;
                end
            end else begin
                if (level == BOT_NEXT) begin
                    level    <= BOT;
                    rising_q <= 1'b1;
                end else begin
                    level <= level - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pwmdc_sync.sv
module pwmdc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= RST_VAL;
                else     chain_q[0] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= RST_VAL;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwmdc_gate.sv
module pwmdc_gate
    import pwmdc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  car_evt_t      evt,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] ctl_word,
    input  drive_mode_e   mode,
    input  logic          pin_n_s,
    input  logic          oc_flag,
    output logic [CW-1:0] ctl_act,
    output logic          oc_lat,
    output logic          pwm_on
);
    logic raw_on;

    // Word adoption and overcurrent release both happen on the boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_act <= '0;
            oc_lat  <= 1'b0;
        end else if (evt.wrap) begin
            ctl_act <= ctl_word;
            oc_lat  <= oc_flag;
        end else begin
            oc_lat  <= oc_lat | oc_flag;
        end
    end

    always_comb begin
        unique case (mode)
            MODE_LEVEL: raw_on = (ctl_act > level);
            MODE_PULSE: raw_on = !pin_n_s;
            default:    raw_on = 1'b0;
        endcase
        pwm_on = raw_on && !oc_lat;
    end
endmodule

// File: rtl/pwm_duty_ctrl.sv
module pwm_duty_ctrl
    import pwmdc_pkg::*;
#(
    parameter int CW          = 8,    // control word and carrier width
    parameter int PW          = 12,   // prescaler divider width
    parameter int LO          = 48,   // carrier lower bound (0% at or below)
    parameter int HI          = 208,  // carrier upper bound (100% at or above), HI-LO >= 3
    parameter int SYNC_STAGES = 2     // pin synchronizer depth, >= 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] presc_div,
    input  logic [CW-1:0] ctl_word,
    input  logic          mode_pulse,
    input  logic          ext_pwm_n,
    input  logic          oc_flag,
    output logic          pwm_on
);
    localparam int unsigned PERIOD_TICKS = period_ticks(LO, HI);

    logic          car_tick;
    logic [CW-1:0] car_level;
    car_evt_t      car_evt;
    logic          pin_n_s;
    logic [CW-1:0] ctl_act;
    logic          oc_lat;
    drive_mode_e   mode;

    assign mode = drive_mode_e'(mode_pulse);

    pwmdc_prescaler #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .div  (presc_div),
        .tick (car_tick)
    );

    pwmdc_carrier #(.CW(CW), .LO(LO), .HI(HI)) u_carrier (
        .clk   (clk),
        .rst   (rst),
        .tick  (car_tick),
        .level (car_level),
        .evt   (car_evt)
    );

    pwmdc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (ext_pwm_n),
        .q   (pin_n_s)
    );

    pwmdc_gate #(.CW(CW)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .evt      (car_evt),
        .level    (car_level),
        .ctl_word (ctl_word),
        .mode     (mode),
        .pin_n_s  (pin_n_s),
        .oc_flag  (oc_flag),
        .ctl_act  (ctl_act),
        .oc_lat   (oc_lat),
        .pwm_on   (pwm_on)
    );
endmodule

// File: rtl/pwm_duty_ctrl_chk.sv
module pwm_duty_ctrl_chk #(
    parameter int CW = 8,
    parameter int LO = 48,
    parameter int HI = 208
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_pulse,
    input logic          oc_flag,
    input logic          pwm_on,
    input logic [CW-1:0] ctl_word,
    input logic [CW-1:0] level,
    input logic          wrap,
    input logic [CW-1:0] ctl_act,
    input logic          oc_lat,
    input logic          pin_n_s
);
    localparam logic [CW-1:0] BOUND_LO = CW'(LO);
    localparam logic [CW-1:0] BOUND_HI = CW'(HI);
    localparam logic [CW-1:0] LVL_MAX  = CW'(HI - 1);

    AST_RESET_OFF: assert property (@(posedge clk) rst |=> !pwm_on); // R1

    AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!mode_pulse && ctl_act <= BOUND_LO) |-> !pwm_on); // R2

    AST_LEVEL_FULL: assert property (@(posedge clk) disable iff (rst)
        (!mode_pulse && ctl_act >= BOUND_HI && !oc_lat) |-> pwm_on); // R3

    AST_CARRIER_SPAN: assert property (@(posedge clk) disable iff (rst)
        (level >= BOUND_LO && level <= LVL_MAX)); // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(ctl_act)); // R6

    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (ctl_act == $past(ctl_word))); // R6

    AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (mode_pulse && pin_n_s) |-> !pwm_on); // R7

    AST_OC_CUT: assert property (@(posedge clk) disable iff (rst)
        (oc_flag && !wrap) |=> !pwm_on); // R9

    AST_OC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (oc_lat && !wrap) |=> oc_lat); // R9

    AST_OC_REARM: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (oc_lat == $past(oc_flag))); // R10
endmodule

bind pwm_duty_ctrl pwm_duty_ctrl_chk #(.CW(CW), .LO(LO), .HI(HI)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_pulse (mode_pulse),
    .oc_flag    (oc_flag),
    .pwm_on     (pwm_on),
    .ctl_word   (ctl_word),
    .level      (car_level),
    .wrap       (car_evt.wrap),
    .ctl_act    (ctl_act),
    .oc_lat     (oc_lat),
    .pin_n_s    (pin_n_s)
);

// File: tb/pwm_duty_ctrl_test.sv
`timescale 1ns/1ps
module pwm_duty_ctrl_test;
    localparam int CW = 5;
    localparam int PW = 4;
    localparam int LO = 4;
    localparam int HI = 12;
    localparam int PER = 2 * (HI - LO - 1);  // 14 ticks

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] presc_div = '0;
    logic [CW-1:0] ctl_word = '0;
    logic          mode_pulse = 1'b0;
    logic          ext_pwm_n = 1'b1;
    logic          oc_flag = 1'b0;
    logic          pwm_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_duty_ctrl #(.CW(CW), .PW(PW), .LO(LO), .HI(HI), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .presc_div  (presc_div),
        .ctl_word   (ctl_word),
        .mode_pulse (mode_pulse),
        .ext_pwm_n  (ext_pwm_n),
        .oc_flag    (oc_flag),
        .pwm_on     (pwm_on)
    );

    // mode, pin, word, divider, expected on-cycles over one period, requirement
    typedef struct packed {
        logic       mode;
        logic       pin;
        logic [7:0] word;
        logic [3:0] div;
        logic [7:0] exp_on;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{1'b0, 1'b1, 8'd0,  4'd0, 8'd0,  4'd2},  // R2 word zero
        '{1'b0, 1'b1, 8'd4,  4'd0, 8'd0,  4'd2},  // R2 word at lower bound
        '{1'b0, 1'b1, 8'd5,  4'd0, 8'd1,  4'd4},  // R4 one above lower bound
        '{1'b0, 1'b1, 8'd8,  4'd0, 8'd7,  4'd4},  // R4 mid range
        '{1'b0, 1'b1, 8'd11, 4'd0, 8'd13, 4'd4},  // R4 just below upper bound
        '{1'b0, 1'b1, 8'd12, 4'd0, 8'd14, 4'd3},  // R3 at upper bound
        '{1'b0, 1'b1, 8'd31, 4'd0, 8'd14, 4'd3},  // R3 above upper bound
        '{1'b0, 1'b1, 8'd8,  4'd1, 8'd14, 4'd5},  // R5 divide by 2
        '{1'b0, 1'b1, 8'd9,  4'd3, 8'd36, 4'd5},  // R5 divide by 4
        '{1'b0, 1'b0, 8'd4,  4'd0, 8'd0,  4'd8},  // R8 pin low ignored
        '{1'b0, 1'b0, 8'd8,  4'd0, 8'd7,  4'd8},  // R8 pin low does not add duty
        '{1'b1, 1'b0, 8'd0,  4'd0, 8'd14, 4'd7},  // R7 pin low, word zero
        '{1'b1, 1'b1, 8'd31, 4'd0, 8'd0,  4'd7}   // R7 pin high, word full
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_on(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_on) c++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        int guard;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 output during reset", int'(pwm_on), 0);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < 13; v++) begin
            mode_pulse = VECS[v].mode;
            ext_pwm_n  = VECS[v].pin;
            ctl_word   = VECS[v].word[CW-1:0];
            presc_div  = VECS[v].div;
            repeat (3 * PER * 4) @(negedge clk);
            count_on(PER * (int'(VECS[v].div) + 1), c);
            chk($sformatf("R%0d vector %0d", VECS[v].req, v), c, int'(VECS[v].exp_on));
        end

        // Align to a period start using a one-tick word
        mode_pulse = 1'b0;
        ext_pwm_n  = 1'b1;
        presc_div  = '0;
        ctl_word   = 5'd5;
        repeat (60) @(negedge clk);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!pwm_on && guard < 100);
        chk("R4 period marker seen", int'(pwm_on), 1);

        // R6: word changed at offset 0 waits for the boundary
        ctl_word = 5'd11;
        count_on(13, c);
        chk("R6 rest of period keeps old word", c, 0);
        count_on(14, c);
        chk("R6 next period uses new word", c, 13);

        // R9: overcurrent cuts remainder of a full-on period
        ctl_word = 5'd12;
        count_on(4, c);
        chk("R9 on before overcurrent", c, 4);
        oc_flag = 1'b1;
        count_on(1, c);
        oc_flag = 1'b0;
        count_on(9, c);
        chk("R9 off for rest of period", c, 0);
        count_on(14, c);
        chk("R10 cleared at boundary", c, 14);

        // R10: flag high on the boundary cycle keeps next period off
        oc_flag = 1'b1;
        count_on(1, c);
        oc_flag = 1'b0;
        count_on(13, c);
        chk("R10 held across boundary", c, 0);

        // R7: pulse mode, pin low, two-cycle delay at period start
        mode_pulse = 1'b1;
        ext_pwm_n  = 1'b0;
        count_on(14, c);
        chk("R7 pin low after sync delay", c, 13);

        // R9 in pulse mode
        count_on(3, c);
        chk("R9 pulse mode on before cut", c, 3);
        oc_flag = 1'b1;
        count_on(1, c);
        oc_flag = 1'b0;
        count_on(10, c);
        chk("R9 pulse mode off for rest of period", c, 0);
        count_on(14, c);
        chk("R10 pulse mode resumes", c, 14);

        // R7: a five-cycle low pulse on the pin gives five on-cycles
        ext_pwm_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_pwm_n = 1'b0;
        count_on(5, c);
        ext_pwm_n = 1'b1;
        begin
            int c2;
            count_on(7, c2);
            chk("R7 pulse width carried", c + c2, 5);
        end

        // R1: reset mid-run, first period after reset stays off
        mode_pulse = 1'b0;
        ctl_word   = 5'd12;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 output low in reset", int'(pwm_on), 0);
        rst = 1'b0;
        count_on(13, c);
        chk("R1 first period after reset off", c, 0);
        count_on(14, c);
        chk("R3 full drive after first boundary", c, 14);

        finish_run();
    end
endmodule